// File: doc/BRIEF.md
# Conversion Result Register Bank

This block holds the most recent conversion result for each of 28 converter channels and presents them to a bus as 32-bit words at consecutive word addresses. The converter side hands over a channel number, a signed 16-bit result and a one-cycle store strobe. The bus side reads and writes whole words, addressed by byte offset.

Each word carries the result as a sign-extended value in its upper part and two status flags in its low nibble. One flag marks the content as valid. The other records whether software has already fetched the current result. Storing a result occupies a two-cycle update window for that channel. During the window the channel reads as an all-zero word, so a reader that finds the valid flag clear knows to read again. Everything runs on one clock.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every channel word reads as 0x00000000.
- R2: Word layout: the 16-bit result sits in bits 27:12 in two's complement, bits 31:28 repeat the result's bit 15, bit 3 is the valid flag, bit 2 is the already-read flag, and bits 11:4 and 1:0 always read 0.
- R3: Channel n (0 to 27) is at byte offset 4*n, so channel 27 is at 0x6C. Address bits 1:0 are ignored. Any offset from 0x70 upwards reads 0 and bus writes there change no channel.
- R4: A store strobe sampled at clock edge t makes that channel read as 0x00000000, valid flag included, for the two cycles after edge t. The new content becomes readable after edge t+2.
- R5: When the update window ends, the channel holds the new result with the valid flag at 1 and the already-read flag at 0.
- R6: A bus read of a channel that returns a word with the valid flag at 1 sets that channel's already-read flag at the next clock edge. A read in the update window, or a read of a word whose valid flag is 0, leaves the flag unchanged.
- R7: A strobe to a channel that is already in its update window restarts the window from the new strobe, and the newer result is the one stored.
- R8: A bus write to a channel loads bits 27:12 of the write data into the result and bit 2 into the already-read flag. The valid flag does not change, and bits 31:28 follow the written bit 27. If a window ends in the same cycle, the converter's result wins.
- R9: A store strobe with a channel number from 28 to 31 changes no channel.
- R10: A strobe to one channel does not affect what any other channel reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the converter and the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_wr | input | 1 | Store strobe from the converter, one cycle per result |
| cnv_ch | input | 5 | Channel number for the store strobe |
| cnv_data | input | 16 | Signed conversion result |
| bus_rd | input | 1 | Bus read request for the addressed word |
| bus_wr | input | 1 | Bus write request for the addressed word |
| bus_addr | input | 8 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Addressed word, combinational from address |

## Verification
Every channel is stored with a different result value. The values include zero, the largest positive, the most negative and minus one, so a misplaced field or a broken sign extension shows up at once. Each store is followed by reads in both cycles of the window, then by a first and a second read, which separates a window that is too short or too long from a bad already-read flag. Back-to-back strobes to one channel, a strobe to one channel with a read of its neighbour, out-of-range strobes and out-of-range writes show whether the window restarts and whether anything leaks between channels. Bus writes of all ones and all zeros over a valid word, and a write to a channel with no valid data, check which bits software can change.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

  localparam int WORD_W    = 32;
  localparam int RESULT_W  = 16;
  localparam int DATA_LSB  = 12;
  localparam int DATA_MSB  = DATA_LSB + RESULT_W - 1;
  localparam int EXT_W     = WORD_W - DATA_MSB - 1;
  localparam int VALID_BIT = 3;
  localparam int SEEN_BIT  = 2;
  localparam int GAP_W     = DATA_LSB - VALID_BIT - 1;

  typedef logic [RESULT_W-1:0] result_t;
  typedef logic [WORD_W-1:0]   word_t;

  // Assemble a channel word from the stored result and both flags.
  function automatic word_t pack_word(input result_t res, input logic vld, input logic seen);
    word_t w;
    w = {{EXT_W{res[RESULT_W-1]}}, res, {GAP_W{1'b0}}, vld, seen, 2'b00};
    return w;
  endfunction

  // Result field carried by a bus write word.
  function automatic result_t result_of(input word_t w);
    return w[DATA_MSB:DATA_LSB];
  endfunction

endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode #(
  parameter int NUM_CH = 28,
  parameter int ADDR_W = 8,
  parameter int CH_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   idx,
  output logic              hit
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word_idx;
  logic [1:0]        byte_lane_unused;

  assign word_idx         = addr[ADDR_W-1:2];
  assign byte_lane_unused = addr[1:0];
  assign hit              = (int'(word_idx) < NUM_CH);
  assign idx              = hit ? CH_W'(word_idx) : '0;

endmodule

// File: rtl/adc_chan_slot.sv
module adc_chan_slot
  import adc_bank_pkg::*;
#(
  parameter int UPD_CYC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  result_t load_val,
  input  logic    wr_en,
  input  result_t wr_val,
  input  logic    wr_seen,
  input  logic    rd_en,
  output word_t   word,
  output logic    busy,
  output logic    commit,
  output logic    valid,
  output logic    seen
);
  localparam int CNT_W = $clog2(UPD_CYC + 1);

  logic [CNT_W-1:0] win_cnt;
  result_t          pend_q;
  result_t          data_q;
  logic             rd_mark;

  assign busy    = (win_cnt != '0);
  assign commit  = (win_cnt == CNT_W'(1)) && !load;
  assign rd_mark = rd_en && valid && !busy;

  // Update window: a load (re)starts the count, the last count commits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      pend_q  <= '0;
    end else if (load) begin
      win_cnt <= CNT_W'(UPD_CYC);
      pend_q  <= load_val;
    end else if (busy) begin
      win_cnt <= win_cnt - CNT_W'(1);
    end
  end

  // Stored content and flags; commit outranks bus activity.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      valid  <= 1'b0;
      seen   <= 1'b0;
    end else if (commit) begin
      data_q <= pend_q;
      valid  <= 1'b1;
      seen   <= 1'b0;
    end else if (wr_en) begin
      data_q <= wr_val;
      seen   <= wr_seen;
    end else if (rd_mark) begin
      seen   <= 1'b1;
    end
  end

  assign word = busy ? '0 : pack_word(data_q, valid, seen);

endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_bank_pkg::*;
#(
  parameter int NUM_CH = 28,
  parameter int CH_W   = 5
) (
  input  word_t [NUM_CH-1:0] words,
  input  logic [CH_W-1:0]    idx,
  input  logic               hit,
  output word_t              rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit && (idx == CH_W'(i))) rdata = words[i];
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int NUM_CH  = 28,
  parameter int ADDR_W  = 8,
  parameter int UPD_CYC = 2,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnv_wr,
  input  logic [CH_W-1:0]     cnv_ch,
  input  logic [RESULT_W-1:0] cnv_data,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata
);
  // Named internal events, visible to the bound checker.
  logic [CH_W-1:0]     bus_idx;
  logic                bus_hit;
  logic                cnv_hit;
  logic [NUM_CH-1:0]   load_vec;
  logic [NUM_CH-1:0]   wr_vec;
  logic [NUM_CH-1:0]   rd_vec;
  logic [NUM_CH-1:0]   busy_vec;
  logic [NUM_CH-1:0]   commit_vec;
  logic [NUM_CH-1:0]   valid_vec;
  logic [NUM_CH-1:0]   seen_vec;
  word_t [NUM_CH-1:0]  word_vec;
  result_t             wr_result;
  logic                wdata_unused;

  assign cnv_hit      = (int'(cnv_ch) < NUM_CH);
  assign wr_result    = result_of(bus_wdata);
  assign wdata_unused = ^{bus_wdata[WORD_W-1:DATA_MSB+1], bus_wdata[DATA_LSB-1:SEEN_BIT+1],
                          bus_wdata[SEEN_BIT-1:0]};

  adc_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr (bus_addr),
    .idx  (bus_idx),
    .hit  (bus_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    assign load_vec[g] = cnv_wr && cnv_hit && (cnv_ch == CH_W'(g));
    assign wr_vec[g]   = bus_wr && bus_hit && (bus_idx == CH_W'(g));
    assign rd_vec[g]   = bus_rd && !bus_wr && bus_hit && (bus_idx == CH_W'(g));

    adc_chan_slot #(.UPD_CYC(UPD_CYC)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vec[g]),
      .load_val (cnv_data),
      .wr_en    (wr_vec[g]),
      .wr_val   (wr_result),
      .wr_seen  (bus_wdata[SEEN_BIT]),
      .rd_en    (rd_vec[g]),
      .word     (word_vec[g]),
      .busy     (busy_vec[g]),
      .commit   (commit_vec[g]),
      .valid    (valid_vec[g]),
      .seen     (seen_vec[g])
    );
  end

  adc_read_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mux (
    .words (word_vec),
    .idx   (bus_idx),
    .hit   (bus_hit),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/adc_bank_chk.sv
module adc_bank_chk #(
  parameter int NUM_CH = 28,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_wr,
  input logic [CH_W-1:0]   cnv_ch,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_hit,
  input logic [CH_W-1:0]   bus_idx,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] load_vec,
  input logic [NUM_CH-1:0] wr_vec,
  input logic [NUM_CH-1:0] busy_vec,
  input logic [NUM_CH-1:0] commit_vec,
  input logic [NUM_CH-1:0] valid_vec,
  input logic [NUM_CH-1:0] seen_vec
);
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[11:4] == 8'h00) && (bus_rdata[1:0] == 2'b00)); // R2
  AST_SIGN_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:28] == {4{bus_rdata[27]}}); // R2
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> bus_rdata == 32'h0); // R3
  AST_BAD_CH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_wr && (int'(cnv_ch) >= NUM_CH)) |=> ((busy_vec & ~$past(busy_vec)) == '0)); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_WINDOW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit && (bus_idx == CH_W'(i)) && busy_vec[i]) |-> bus_rdata == 32'h0); // R4
    AST_WINDOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[i] |=> busy_vec[i] ##1 busy_vec[i]); // R7
    AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vec[i] |=> valid_vec[i] && !seen_vec[i] && !busy_vec[i]); // R5
    AST_READ_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_hit && (bus_idx == CH_W'(i)) && bus_rdata[3]) |=> seen_vec[i]); // R6
    AST_WRITE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vec[i] && !commit_vec[i]) |=> valid_vec[i] == $past(valid_vec[i])); // R8
  end
endmodule

bind adc_result_bank adc_bank_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnv_wr     (cnv_wr),
  .cnv_ch     (cnv_ch),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_hit    (bus_hit),
  .bus_idx    (bus_idx),
  .bus_rdata  (bus_rdata),
  .load_vec   (load_vec),
  .wr_vec     (wr_vec),
  .busy_vec   (busy_vec),
  .commit_vec (commit_vec),
  .valid_vec  (valid_vec),
  .seen_vec   (seen_vec)
);

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;
  localparam int NCH = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_wr = 1'b0;
  logic [4:0]  cnv_ch = '0;
  logic [15:0] cnv_data = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_data [NCH];
  logic        m_valid [NCH];
  logic        m_seen [NCH];

  always #2.5 clk = ~clk;

  adc_result_bank dut (
    .clk(clk), .rst_n(rst_n), .cnv_wr(cnv_wr), .cnv_ch(cnv_ch), .cnv_data(cnv_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Expected word computed arithmetically: signed result scaled by 4096, flags weighted 8 and 4.
  function automatic logic [31:0] expect_word(input logic [15:0] d, input logic v, input logic s);
    int w;
    w = int'($signed(d)) * 4096 + (v ? 8 : 0) + (s ? 4 : 0);
    return 32'(w);
  endfunction

  function automatic logic [15:0] sweep_val(input int ch);
    case (ch)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      default: return 16'((ch * 2731 + 17) ^ ((ch % 2 == 1) ? 32'h8000 : 32'h0));
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd(input int addr, input bit in_window, input string tag);
    int ch;
    logic [31:0] exp;
    ch = addr / 4;
    @(negedge clk);
    bus_rd = 1'b1;
    bus_addr = 8'(addr);
    #1;
    if (ch >= NCH || in_window) exp = 32'h0;
    else exp = expect_word(m_data[ch], m_valid[ch], m_seen[ch]);
    check(tag, bus_rdata, exp);
    @(posedge clk);
    #1 bus_rd = 1'b0;
    if (ch < NCH && !in_window && m_valid[ch]) m_seen[ch] = 1'b1;
  endtask

  task automatic conv(input int ch, input logic [15:0] val);
    @(negedge clk);
    cnv_wr = 1'b1;
    cnv_ch = 5'(ch);
    cnv_data = val;
    @(posedge clk);
    #1 cnv_wr = 1'b0;
    if (ch < NCH) begin
      m_data[ch] = val;
      m_valid[ch] = 1'b1;
      m_seen[ch] = 1'b0;
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] val);
    int ch;
    ch = addr / 4;
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 8'(addr);
    bus_wdata = val;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (ch < NCH) begin
      m_data[ch] = val[27:12];
      m_seen[ch] = val[2];
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_data[i] = '0; m_valid[i] = 1'b0; m_seen[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R3: every word offset after reset
    for (int a = 0; a < 64; a++) rd(a * 4, 1'b0, (a < NCH) ? "R1 reset word" : "R3 unmapped read");

    // R8 / R6: write to a channel with no valid data; reads leave the flag alone
    wr(4, 32'h12345678);
    rd(4, 1'b0, "R8 write without valid");
    rd(4, 1'b0, "R6 invalid read keeps flag");
    check("R8 written word", expect_word(m_data[1], 1'b0, 1'b0), 32'h02345000);

    // R2 / R4 / R5 / R6: store and read every channel
    for (int ch = 0; ch < NCH; ch++) begin
      conv(ch, sweep_val(ch));
      rd(ch * 4, 1'b1, "R4 window cycle 1");
      rd(ch * 4 + 2, 1'b1, "R4 window cycle 2");
      rd(ch * 4, 1'b0, "R5 first read after window");
      rd(ch * 4, 1'b0, "R6 second read shows flag");
    end
    check("R2 most negative", expect_word(16'h8000, 1'b1, 1'b0), 32'hF8000008);

    // R7: back-to-back strobes restart the window
    conv(5, 16'h1111);
    conv(5, 16'hABCD);
    rd(20, 1'b1, "R7 restarted window 1");
    rd(20, 1'b1, "R7 restarted window 2");
    rd(20, 1'b0, "R7 newer value stored");

    // R10: neighbour unaffected
    conv(7, 16'h4242);
    rd(32, 1'b0, "R10 neighbour readable");
    rd(28, 1'b1, "R4 own window");
    rd(28, 1'b0, "R10 own value after window");

    // R8: bus writes over valid data
    wr(12, 32'hFFFFFFFF);
    rd(12, 1'b0, "R8 all-ones write");
    wr(12, 32'h00000000);
    rd(12, 1'b0, "R8 all-zeros write");

    // R9: out-of-range strobes
    for (int c = NCH; c < 32; c++) conv(c, 16'h5A5A);
    repeat (3) @(posedge clk);
    for (int ch = 0; ch < NCH; ch++) rd(ch * 4, 1'b0, "R9 bad channel ignored");

    // R3: writes beyond the bank
    wr(8'h70, 32'h7FFFF004);
    wr(8'hFC, 32'h7FFFF004);
    for (int ch = 0; ch < NCH; ch++) rd(ch * 4, 1'b0, "R3 unmapped write ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule